// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimation Filter

This block turns the 1-bit output of a delta-sigma modulator into 24-bit words. Three integrators run at the modulator sample rate and three differentiators run at the decimated rate. Together they form a sinc-cubed low-pass. A 12-bit code chooses the decimation ratio N. One output word appears for every N accepted modulator samples. The first notch of the response therefore sits at the sample rate divided by N. The sample strobe is nominally the master clock divided by 128.

Software can restart the filter in three ways: hold the active-low sync pin, set the sync bit, or pulse the channel-change request. Each clears every accumulator. The first settled word then arrives three output periods after release, where a step that arrives without a restart can take up to four periods. A settled flag goes with each word. A new code is taken only at a filter restart, and power-on reset counts as a restart.

Top module: `sinc3_decim_filter`

## Requirements
- R1: After a filter restart with the modulator held at 1, the unscaled words k = 1, 2, 3 equal C(N+2,3), C(2N+2,3) − 3·C(N+2,3) and N³. Every later word stays at N³. With the modulator held at 0, every word is 0.
- R2: The ratio N is the code clamped to the range 19 to 4000. Exactly N accepted strobes separate successive words, which puts the first notch at the strobe rate divided by N.
- R3: The raw word is shifted right by s = max(0, bitlen(N³) − 24). Full scale is therefore N³ >> s and always fits in 24 bits.
- R4: With `unipolar` = 0 the result is offset binary: the scaled value itself. With `unipolar` = 1 the result is straight binary: 0 when the scaled value is below 2^23, otherwise 2·(scaled − 2^23).
- R5: `data_ready` is high for exactly one clock per word, and `result` holds its value between words.
- R6: In any clock where `sync_n` is 0, `sync_bit` is 1 or `chan_change` is 1, the filter is cleared. Strobes in that clock are ignored, no word is issued while the restart is held, and `result` and `settled` read 0 in the following clock.
- R7: After a restart, the first two words carry `settled` = 0. The third word and all later ones carry `settled` = 1.
- R8: A change of `code_in` has no effect on word spacing until the next restart. Power-on reset counts as a restart.
- R9: An input step with no restart leaves `settled` at 1. The fourth complete word after the step has the new steady value.
- R10: Once `rst_n` is released, `result` is 0 and both `data_ready` and `settled` are 0 until the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_strobe | input | 1 | Modulator sample valid |
| mod_bit | input | 1 | Modulator bitstream sample |
| code_in | input | 12 | Decimation code |
| sync_n | input | 1 | Active-low filter hold pin |
| sync_bit | input | 1 | Filter hold control bit |
| chan_change | input | 1 | Channel-change request, filter restart |
| unipolar | input | 1 | 1 selects straight binary coding |
| result | output | 24 | Filter output word |
| data_ready | output | 1 | One-cycle new-word strobe |
| settled | output | 1 | Current word is past the restart transient |

## Verification
The bench drives codes below 19 and above 4000. A design that does not clamp them would produce words at the wrong spacing and values that do not match the clamped N³. It checks the two partial words after each restart by exact value and flag. An off-by-one in the comb ordering or in the settle counter would show up as a wrong sum or a `settled` flag one word early or late. It changes the code without a restart and then with one. A design that loads the code immediately would change the spacing too soon. Finally, it applies a mid-word step with no restart and requires the fourth word to be exactly zero while `settled` stays high.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   // Limit a requested code to the legal ratio window.
   function automatic int clamp_code(input int c, input int lo, input int hi);
      if (c < lo) return lo;
      if (c > hi) return hi;
      return c;
   endfunction

   // Right shift that brings the full-scale value N^3 into out_w bits.
   function automatic int calc_shift(input int n, input int out_w);
      longint unsigned cube;
      int              b;
      cube = longint'(n) * longint'(n) * longint'(n);
      b    = 0;
      for (int i = 0; i < 64; i++) begin
         if (cube[i]) b = i + 1;
      end
      return (b > out_w) ? (b - out_w) : 0;
   endfunction

endpackage

// File: rtl/sinc3_ratio_ctl.sv
module sinc3_ratio_ctl #(
   parameter int CODE_W   = 12,
   parameter int CODE_MIN = 19,
   parameter int CODE_MAX = 4000,
   parameter int ORDER    = 3,
   parameter int OUT_W    = 24,
   parameter int SH_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_req,
   input  logic              strobe,
   input  logic [CODE_W-1:0] code_in,
   output logic              clr,
   output logic [SH_W-1:0]   shift_q,
   output logic              tick_q,
   output logic              tick_settled_q
);
   localparam int WC_W = $clog2(ORDER + 1);

   logic              armed_q;
   logic [CODE_W-1:0] ratio_q;
   logic [CODE_W-1:0] cnt_q;
   logic [WC_W-1:0]   wcnt_q;
   logic [CODE_W-1:0] code_cl;
   logic [SH_W-1:0]   shift_nxt;
   logic              last_sample;

   assign clr = restart_req | ~armed_q;

   always_comb begin
      code_cl   = CODE_W'(sinc3_pkg::clamp_code(int'(code_in), CODE_MIN, CODE_MAX));
      shift_nxt = SH_W'(sinc3_pkg::calc_shift(int'(code_cl), OUT_W));
   end

   assign last_sample = (cnt_q == ratio_q - CODE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q        <= 1'b0;
         ratio_q        <= CODE_W'(CODE_MIN);
         shift_q        <= '0;
         cnt_q          <= '0;
         wcnt_q         <= '0;
         tick_q         <= 1'b0;
         tick_settled_q <= 1'b0;
      end else if (clr) begin
         armed_q        <= 1'b1;
         ratio_q        <= code_cl;
         shift_q        <= shift_nxt;
         cnt_q          <= '0;
         wcnt_q         <= '0;
         tick_q         <= 1'b0;
         tick_settled_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (strobe) begin
            if (last_sample) begin
               cnt_q          <= '0;
               tick_q         <= 1'b1;
               tick_settled_q <= (int'(wcnt_q) >= ORDER - 1);
               if (int'(wcnt_q) < ORDER - 1) wcnt_q <= wcnt_q + WC_W'(1);
            end else begin
               cnt_q <= cnt_q + CODE_W'(1);
            end
         end
      end
   end

   assert_ratio_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (int'(ratio_q) >= CODE_MIN && int'(ratio_q) <= CODE_MAX));

   assert_cnt_below_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (cnt_q < ratio_q));

   assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !restart_req) |=> $stable(ratio_q));

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int ORDER = 3,
   parameter int ACC_W = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe,
   input  logic             din,
   output logic [ACC_W-1:0] integ_out
);
   logic [ACC_W-1:0] acc_q [ORDER];
   logic [ACC_W-1:0] acc_n [ORDER];

   for (genvar s = 0; s < ORDER; s++) begin : g_stage
      if (s == 0) begin : g_first
         assign acc_n[s] = acc_q[s] + ACC_W'(din);
      end else begin : g_rest
         assign acc_n[s] = acc_q[s] + acc_n[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc_q[s] <= '0;
         else if (clr)    acc_q[s] <= '0;
         else if (strobe) acc_q[s] <= acc_n[s];
      end
   end

   assign integ_out = acc_q[ORDER-1];

   assert_first_stage_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !strobe) |=> $stable(acc_q[0]));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int ORDER = 3,
   parameter int ACC_W = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             tick_settled,
   input  logic [ACC_W-1:0] integ_in,
   output logic [ACC_W-1:0] raw_q,
   output logic             vld_q,
   output logic             set_q
);
   logic [ACC_W-1:0] dly_q  [ORDER];
   logic [ACC_W-1:0] stg_in [ORDER];
   logic [ACC_W-1:0] stg_out[ORDER];

   for (genvar s = 0; s < ORDER; s++) begin : g_diff
      if (s == 0) begin : g_first
         assign stg_in[s] = integ_in;
      end else begin : g_rest
         assign stg_in[s] = stg_out[s-1];
      end
      assign stg_out[s] = stg_in[s] - dly_q[s];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    dly_q[s] <= '0;
         else if (clr)  dly_q[s] <= '0;
         else if (tick) dly_q[s] <= stg_in[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         vld_q <= 1'b0;
         set_q <= 1'b0;
      end else if (clr) begin
         raw_q <= '0;
         vld_q <= 1'b0;
         set_q <= 1'b0;
      end else begin
         vld_q <= tick;
         if (tick) begin
            raw_q <= stg_out[ORDER-1];
            set_q <= tick_settled;
         end
      end
   end

   assert_word_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
   parameter int ACC_W = 37,
   parameter int OUT_W = 24,
   parameter int SH_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             vld,
   input  logic             set_in,
   input  logic [ACC_W-1:0] raw,
   input  logic [SH_W-1:0]  shift,
   input  logic             unipolar,
   output logic [OUT_W-1:0] result,
   output logic             data_ready,
   output logic             settled
);
   logic [OUT_W-1:0] scaled;
   logic [OUT_W-1:0] coded;

   assign scaled = OUT_W'(raw >> shift);

   always_comb begin
      if (!unipolar)              coded = scaled;
      else if (scaled[OUT_W-1])   coded = {scaled[OUT_W-2:0], 1'b0};
      else                        coded = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result     <= '0;
         data_ready <= 1'b0;
         settled    <= 1'b0;
      end else if (clr) begin
         result     <= '0;
         data_ready <= 1'b0;
         settled    <= 1'b0;
      end else begin
         data_ready <= vld;
         if (vld) begin
            result  <= coded;
            settled <= set_in;
         end
      end
   end

   assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |=> !data_ready);

   assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld && !clr) |=> $stable(result));

   assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!data_ready && !settled && result == '0));

   assert_settle_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> data_ready);

endmodule

// File: rtl/sinc3_decim_filter.sv
module sinc3_decim_filter #(
   parameter int CODE_W   = 12,
   parameter int CODE_MIN = 19,
   parameter int CODE_MAX = 4000,
   parameter int ORDER    = 3,
   parameter int OUT_W    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_strobe,
   input  logic              mod_bit,
   input  logic [CODE_W-1:0] code_in,
   input  logic              sync_n,
   input  logic              sync_bit,
   input  logic              chan_change,
   input  logic              unipolar,
   output logic [OUT_W-1:0]  result,
   output logic              data_ready,
   output logic              settled
);
   localparam int ACC_W = ORDER * CODE_W + 1;
   localparam int SH_W  = $clog2(ACC_W + 1);

   if (CODE_MIN < 2 || CODE_MAX < CODE_MIN || CODE_MAX >= (1 << CODE_W)) begin : g_bad_range
      $error("sinc3_decim_filter: illegal code range");
   end
   if (OUT_W < 2 || OUT_W > ACC_W || ORDER < 1) begin : g_bad_width
      $error("sinc3_decim_filter: illegal width or order");
   end

   logic             restart_req;
   logic             clr;
   logic [SH_W-1:0]  shift_q;
   logic             tick_q;
   logic             tick_set_q;
   logic [ACC_W-1:0] integ_out;
   logic [ACC_W-1:0] raw_q;
   logic             vld_q;
   logic             set_q;

   assign restart_req = ~sync_n | sync_bit | chan_change;

   sinc3_ratio_ctl #(
      .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX),
      .ORDER(ORDER), .OUT_W(OUT_W), .SH_W(SH_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .strobe(mod_strobe),
      .code_in(code_in), .clr(clr), .shift_q(shift_q), .tick_q(tick_q),
      .tick_settled_q(tick_set_q)
   );

   sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(mod_strobe),
      .din(mod_bit), .integ_out(integ_out)
   );

   sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_q),
      .tick_settled(tick_set_q), .integ_in(integ_out),
      .raw_q(raw_q), .vld_q(vld_q), .set_q(set_q)
   );

   sinc3_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
      .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld_q), .set_in(set_q),
      .raw(raw_q), .shift(shift_q), .unipolar(unipolar),
      .result(result), .data_ready(data_ready), .settled(settled)
   );

   assert_no_word_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !data_ready);

endmodule

// File: tb/sinc3_decim_filter_bench.sv
module sinc3_decim_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_strobe = 1'b0;
   logic        mod_bit = 1'b0;
   logic [11:0] code_in = 12'd19;
   logic        sync_n = 1'b1;
   logic        sync_bit = 1'b0;
   logic        chan_change = 1'b0;
   logic        unipolar = 1'b0;
   logic [23:0] result;
   logic        data_ready;
   logic        settled;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   longint wval [0:255];
   bit     wset [0:255];
   int     wpos [0:255];
   int     wn = 0;
   int     scount = 0;

   always #10 clk = ~clk;

   sinc3_decim_filter u_sinc3_decim_filter (
      .clk(clk), .rst_n(rst_n), .mod_strobe(mod_strobe), .mod_bit(mod_bit),
      .code_in(code_in), .sync_n(sync_n), .sync_bit(sync_bit),
      .chan_change(chan_change), .unipolar(unipolar),
      .result(result), .data_ready(data_ready), .settled(settled)
   );

   // Stimulus / expected table: code, unipolar, bit level, settled word value
   localparam int NV = 8;
   localparam int V_CODE [0:NV-1] = '{19, 19, 4000, 300, 300, 5, 4095, 100};
   localparam int V_UNI  [0:NV-1] = '{0, 0, 0, 0, 1, 0, 1, 0};
   localparam int V_BIT  [0:NV-1] = '{1, 0, 1, 1, 1, 1, 1, 0};
   localparam int V_EXP  [0:NV-1] = '{6859, 0, 15625000, 13500000, 10222784, 6859, 14472784, 0};

   always begin
      @(negedge clk);
      #1;
      if (data_ready && wn < 256) begin
         wval[wn] = longint'(result);
         wset[wn] = settled;
         wpos[wn] = scount;
         wn++;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint c3(input longint k);
      return (k * (k - 1) * (k - 2)) / 6;
   endfunction

   function automatic int eff_n(input int code);
      return (code < 19) ? 19 : ((code > 4000) ? 4000 : code);
   endfunction

   function automatic longint expect_word(input int n, input int m, input int b, input int uni);
      longint raw, sc, cube;
      int bl, sh;
      if (b == 0) raw = 0;
      else if (m == 1) raw = c3(n + 2);
      else if (m == 2) raw = c3(2 * n + 2) - 3 * c3(n + 2);
      else raw = longint'(n) * n * n;
      cube = longint'(n) * n * n;
      bl = 0;
      for (int i = 0; i < 63; i++) if (cube >= (64'sd1 <<< i)) bl = i + 1;
      sh = (bl > 24) ? bl - 24 : 0;
      sc = raw >>> sh;
      if (uni != 0) sc = (sc < 8388608) ? 0 : 2 * (sc - 8388608);
      return sc;
   endfunction

   task automatic do_strobe(input bit b);
      @(negedge clk);
      mod_strobe = 1'b1;
      mod_bit = b;
      scount++;
      @(negedge clk);
      mod_strobe = 1'b0;
      #2;
   endtask

   task automatic collect(input int nw, input bit b);
      int target;
      int guard;
      target = wn + nw;
      guard = 0;
      while (wn < target && guard < 20000) begin
         do_strobe(b);
         guard++;
      end
   endtask

   task automatic pulse_chan();
      @(negedge clk);
      chan_change = 1'b1;
      @(negedge clk);
      chan_change = 1'b0;
      #2;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int base;
      // R10: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(result == 24'd0, "R10 result after reset", longint'(result), 0);
      chk(data_ready == 1'b0, "R10 data_ready after reset", longint'(data_ready), 0);
      chk(settled == 1'b0, "R10 settled after reset", longint'(settled), 0);

      // Table walk: R1 R2 R3 R4 R7
      for (int v = 0; v < NV; v++) begin
         int n;
         n = eff_n(V_CODE[v]);
         code_in = 12'(V_CODE[v]);
         unipolar = V_UNI[v][0];
         pulse_chan();
         base = wn;
         collect(4, V_BIT[v][0]);
         for (int m = 1; m <= 4; m++) begin
            chk(wval[base+m-1] == expect_word(n, m, V_BIT[v], V_UNI[v]),
                $sformatf("R1 R3 R4 vec%0d word%0d", v, m), wval[base+m-1],
                expect_word(n, m, V_BIT[v], V_UNI[v]));
            chk(wset[base+m-1] == (m >= 3), $sformatf("R7 vec%0d word%0d settled", v, m),
                longint'(wset[base+m-1]), longint'(m >= 3));
         end
         chk(wval[base+2] == longint'(V_EXP[v]), $sformatf("R3 vec%0d full scale", v),
             wval[base+2], longint'(V_EXP[v]));
         chk(wpos[base+1] - wpos[base] == n, $sformatf("R2 vec%0d spacing", v),
             longint'(wpos[base+1] - wpos[base]), longint'(n));
         chk(wpos[base+3] - wpos[base+2] == n, $sformatf("R2 vec%0d spacing late", v),
             longint'(wpos[base+3] - wpos[base+2]), longint'(n));
      end
      unipolar = 1'b0;

      // R8: code change waits for a restart
      code_in = 12'd100;
      pulse_chan();
      collect(2, 1'b1);
      code_in = 12'd40;
      base = wn;
      collect(2, 1'b1);
      chk(wpos[base+1] - wpos[base] == 100, "R8 spacing before restart",
          longint'(wpos[base+1] - wpos[base]), 100);
      @(negedge clk);
      sync_bit = 1'b1;
      @(negedge clk);
      sync_bit = 1'b0;
      #2;
      base = wn;
      collect(2, 1'b1);
      chk(wpos[base+1] - wpos[base] == 40, "R8 spacing after sync bit",
          longint'(wpos[base+1] - wpos[base]), 40);

      // R6: hold through the sync pin
      @(negedge clk);
      sync_n = 1'b0;
      #2;
      base = wn;
      for (int i = 0; i < 60; i++) do_strobe(1'b1);
      chk(wn == base, "R6 no words while held", longint'(wn - base), 0);
      chk(settled == 1'b0, "R6 settled cleared in hold", longint'(settled), 0);
      chk(result == 24'd0, "R6 result cleared in hold", longint'(result), 0);
      @(negedge clk);
      sync_n = 1'b1;
      #2;
      base = wn;
      collect(3, 1'b1);
      chk(wval[base] == 11480, "R6 R1 first word after release", wval[base], 11480);
      chk(wset[base+1] == 1'b0, "R7 second word after release", longint'(wset[base+1]), 0);
      chk(wset[base+2] == 1'b1, "R7 third word after release", longint'(wset[base+2]), 1);
      chk(wval[base+2] == 64000, "R1 settled after release", wval[base+2], 64000);

      // R9: mid-word step with no restart
      collect(1, 1'b1);
      for (int i = 0; i < 7; i++) do_strobe(1'b1);
      base = wn;
      collect(4, 1'b0);
      chk(wval[base] != 0, "R9 first word after step partial", wval[base], -1);
      chk(wval[base+3] == 0, "R9 fourth word after step", wval[base+3], 0);
      chk(wset[base] == 1'b1 && wset[base+3] == 1'b1, "R9 settled stays high",
          longint'(wset[base] & wset[base+3]), 1);

      // R6 R7: channel change drops settled at once
      pulse_chan();
      chk(settled == 1'b0, "R6 R7 settled after channel change", longint'(settled), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule